// File: doc/BRIEF.md
# Base Address Register with Window Decode

This block holds the base address of one target window on a system bus and decides, for every incoming bus address, whether that address falls inside the window. System software reaches it through a 32-bit configuration read/write port. The register only stores the address bits above the window size. All lower bits read back as zero or as fixed attribute bits. So the usual probe works: write all ones, read back, clear the attribute field and negate. That yields the window size in bytes. Software then writes the base it has allocated into the same register.

The window size is a power-of-two parameter of at least 16 bytes. Elaboration stops on any other value. The attribute field is hardwired. In the default memory variant, bit 0 is 0 (memory space), bits 2:1 are 00 (32-bit placement anywhere) and bit 3 reports prefetchability from a parameter. An I/O-space variant, chosen by parameter, uses a two-bit attribute field with bit 0 set. The hit output is combinational from the bus address. It is held low while the decode-enable input, driven from the command register, is clear.

Top module: `bar_window_decode`

## Requirements
- R1: After reset, the configuration readback returns zero in every address bit together with the fixed attribute bits. With a 4 KiB prefetchable window this value is 0x0000_0008.
- R2: After a write of 0xFFFF_FFFF with all four byte enables set, the readback is the size mask with the attribute bits. Clearing bits 3:0 of that value and taking the two's complement gives the window size in bytes. With 4 KiB, prefetchable, the readback is 0xFFFF_F008.
- R3: Bit 0 reads 0 (memory), bits 2:1 read 00 (32-bit type) and bit 3 reads the prefetch parameter. No write changes these bits.
- R4: Address bits 4 through log2(window)-1 always read zero, whatever value is written.
- R5: A configuration write updates only the bytes whose enable is set. Byte enable bit n covers data bits 8n+7:8n. A write with no byte enable set changes nothing.
- R6: The hit output is 0 whenever decode enable is 0, even for an address inside the window.
- R7: With decode enable set, hit is 1 exactly for addresses from the stored base up to base plus window size minus one. Both edges are inclusive at the base and exclusive at base plus size.
- R8: Hit follows a change of bus address or decode enable in the same cycle, with no clock edge in between.
- R9: Reset returns a previously assigned base to zero, so the readback returns to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration write port |
| rst_n | input | 1 | Active-low reset, clears the stored base |
| cfg_wr | input | 1 | Configuration write strobe, sampled on the rising clock edge |
| cfg_be | input | 4 | Byte enables for the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of stored base bits and attribute bits |
| decode_en | input | 1 | Decode enable from the command register |
| bus_addr | input | 32 | Incoming bus address to be compared |
| hit | output | 1 | High when bus_addr lies inside the assigned window and decode is enabled |

## Verification
Any wrong stored base bit shows up in the configuration readback on the cycle right after the write that caused it. The same bit also moves the hit window, which is seen as soon as an address near the window edge is presented. A writable bit that should be hardwired shows as a wrong size mask after the all-ones probe. A byte-enable mistake shows as a foreign byte in the readback after a partial write. A missing decode gate shows as a hit while decode enable is low, on the same cycle the address is applied.

// File: rtl/bar_pkg.sv
package bar_pkg;

   localparam int unsigned DWORD_W = 32;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned NUM_BE  = DWORD_W / BYTE_W;

   typedef logic [DWORD_W-1:0] dword_t;
   typedef logic [NUM_BE-1:0]  be_t;

   // Number of attribute bits at the bottom of the register
   function automatic int unsigned attr_width(input bit io_space);
      return io_space ? 2 : 4;
   endfunction

   // Mask of the bits that hold the assigned base
   function automatic dword_t base_mask(input longint unsigned win_bytes,
                                        input bit io_space);
      dword_t win_m;
      dword_t att_m;
      win_m = dword_t'(win_bytes - 1);
      att_m = dword_t'((64'd1 << attr_width(io_space)) - 1);
      return ~(win_m | att_m);
   endfunction

endpackage

// File: rtl/bar_attr.sv
module bar_attr
   import bar_pkg::*;
#(
   parameter bit IO_SPACE = 1'b0,
   parameter bit PREFETCH = 1'b0
) (
   output dword_t attr_o
);

   localparam int unsigned ATTR_W = attr_width(IO_SPACE);

   logic [ATTR_W-1:0] field;

   generate
      if (IO_SPACE) begin : g_io
         // bit0 = 1 : I/O space, bit1 reserved zero
         assign field = 2'b01;
      end else begin : g_mem
         // bit0 = 0 : memory, bits2:1 = 00 : 32-bit, bit3 = prefetchable
         assign field = {PREFETCH, 2'b00, 1'b0};
      end
   endgenerate

   assign attr_o = dword_t'(field);

endmodule

// File: rtl/bar_store.sv
module bar_store
   import bar_pkg::*;
#(
   parameter dword_t WMASK = 32'hFFFF_F000
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wr_i,
   input  be_t    be_i,
   input  dword_t wdata_i,
   output dword_t base_o
);

   dword_t base_q;

   generate
      for (genvar gb = 0; gb < NUM_BE; gb++) begin : g_byte
         localparam logic [BYTE_W-1:0] BMASK = WMASK[gb*BYTE_W +: BYTE_W];
         if (BMASK == '0) begin : g_fixed
            assign base_q[gb*BYTE_W +: BYTE_W] = '0;
         end else begin : g_reg
            logic [BYTE_W-1:0] byte_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  byte_q <= '0;
               end else if (wr_i && be_i[gb]) begin
                  byte_q <= wdata_i[gb*BYTE_W +: BYTE_W] & BMASK;
               end
            end
            assign base_q[gb*BYTE_W +: BYTE_W] = byte_q;
         end
      end
   endgenerate

   assign base_o = base_q;

endmodule

// File: rtl/bar_hit.sv
module bar_hit
   import bar_pkg::*;
#(
   parameter dword_t WMASK = 32'hFFFF_F000
) (
   input  dword_t addr_i,
   input  dword_t base_i,
   input  logic   en_i,
   output logic   hit_o
);

   dword_t diff;

   always_comb begin
      diff  = (addr_i ^ base_i) & WMASK;
      hit_o = en_i && (diff == '0);
   end

endmodule

// File: rtl/bar_window_decode.sv
module bar_window_decode
   import bar_pkg::*;
#(
   parameter longint unsigned WIN_BYTES = 4096,
   parameter bit              PREFETCH  = 1'b0,
   parameter bit              IO_SPACE  = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [3:0]  cfg_be,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic        decode_en,
   input  logic [31:0] bus_addr,
   output logic        hit
);

   localparam longint unsigned MIN_WIN = IO_SPACE ? 4 : 16;
   localparam dword_t          WMASK   = base_mask(WIN_BYTES, IO_SPACE);

   generate
      if ((WIN_BYTES & (WIN_BYTES - 1)) != 0) begin : g_bad_pow2
         $error("WIN_BYTES must be a power of two");
      end
      if (WIN_BYTES < MIN_WIN) begin : g_bad_small
         $error("WIN_BYTES below the minimum window");
      end
      if (WIN_BYTES > 64'h8000_0000) begin : g_bad_large
         $error("WIN_BYTES exceeds the 32-bit space");
      end
   endgenerate

   dword_t attr_v;
   dword_t base_v;

   bar_attr #(
      .IO_SPACE (IO_SPACE),
      .PREFETCH (PREFETCH)
   ) u_attr (
      .attr_o (attr_v)
   );

   bar_store #(
      .WMASK (WMASK)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cfg_wr),
      .be_i    (cfg_be),
      .wdata_i (cfg_wdata),
      .base_o  (base_v)
   );

   bar_hit #(
      .WMASK (WMASK)
   ) u_hit (
      .addr_i (bus_addr),
      .base_i (base_v),
      .en_i   (decode_en),
      .hit_o  (hit)
   );

   assign cfg_rdata = base_v | attr_v;

endmodule

// File: rtl/bar_window_decode_chk.sv
module bar_window_decode_chk #(
   parameter logic [31:0] WMASK = 32'hFFFF_F000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_wr,
   input logic [3:0]  cfg_be,
   input logic [31:0] cfg_wdata,
   input logic [31:0] cfg_rdata,
   input logic        decode_en,
   input logic [31:0] bus_addr,
   input logic        hit
);

   AST_RESET_CLEARS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((cfg_rdata & WMASK) == 32'h0)); // R9

   AST_FULL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_be == 4'hF) |=> ((cfg_rdata & WMASK) == ($past(cfg_wdata) & WMASK))); // R2

   AST_ATTR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(cfg_rdata[3:0])); // R3

   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_rdata & ~WMASK & 32'hFFFF_FFF0) == 32'h0)); // R4

   AST_NO_BE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr || cfg_be == 4'h0) |=> $stable(cfg_rdata)); // R5

   AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !decode_en |-> !hit); // R6

   AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (decode_en && (((bus_addr ^ cfg_rdata) & WMASK) == 32'h0)) |-> hit); // R7

   AST_MISS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (((bus_addr ^ cfg_rdata) & WMASK) != 32'h0) |-> !hit); // R7

endmodule

bind bar_window_decode bar_window_decode_chk #(
   .WMASK (WMASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_be    (cfg_be),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .decode_en (decode_en),
   .bus_addr  (bus_addr),
   .hit       (hit)
);

// File: tb/bar_window_decode_tb.sv
module bar_window_decode_tb;

   localparam longint unsigned WIN = 4096;
   localparam bit              PF  = 1'b1;
   localparam logic [31:0]     ATTR = {28'h0, PF, 3'b000};
   localparam logic [31:0]     MASK = ~(32'(WIN) - 32'd1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_be = 4'h0;
   logic [31:0] cfg_wdata = 32'h0;
   logic [31:0] cfg_rdata;
   logic        decode_en = 1'b0;
   logic [31:0] bus_addr = 32'h0;
   logic        hit;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   bit          done = 1'b0;

   logic [31:0] m_base = 32'h0;

   typedef struct {
      logic [31:0] rd;
      logic        hit;
      string       tag;
   } exp_t;

   exp_t q[$];
   event go;

   always #4 clk = ~clk;

   bar_window_decode #(
      .WIN_BYTES (WIN),
      .PREFETCH  (PF),
      .IO_SPACE  (1'b0)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .decode_en (decode_en),
      .bus_addr  (bus_addr),
      .hit       (hit)
   );

   function automatic logic exp_hit();
      logic [32:0] lo;
      logic [32:0] hi;
      lo = {1'b0, m_base};
      hi = lo + 33'(WIN);
      return decode_en && ({1'b0, bus_addr} >= lo) && ({1'b0, bus_addr} < hi);
   endfunction

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         exp_t e;
         @(go);
         #1;
         e = q.pop_front();
         n_chk++;
         if (cfg_rdata !== e.rd) begin
            n_fail++;
            $display("FAIL %s rdata actual=%h expected=%h", e.tag, cfg_rdata, e.rd);
         end else if (hit !== e.hit) begin
            n_fail++;
            $display("FAIL %s hit actual=%b expected=%b", e.tag, hit, e.hit);
         end
      end
   end

   // driver side: push the expected item and let the monitor sample
   task automatic expect_now(input string tag);
      exp_t e;
      e.rd  = m_base | ATTR;
      e.hit = exp_hit();
      e.tag = tag;
      q.push_back(e);
      -> go;
      #2;
   endtask

   task automatic cfg_write(input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_be    = be;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      cfg_be = 4'h0;
      for (int b = 0; b < 4; b++) begin
         if (be[b]) m_base[b*8 +: 8] = d[b*8 +: 8];
      end
      m_base = m_base & MASK;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_base = 32'h0;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] sz;
      do_reset();
      @(negedge clk);
      expect_now("R1 reset readback");
      decode_en = 1'b0;
      bus_addr  = 32'h0000_0010;
      expect_now("R6 no hit with decode off after reset");

      cfg_write(32'hFFFF_FFFF, 4'hF);
      expect_now("R2 all-ones probe readback");
      sz = ~(cfg_rdata & 32'hFFFF_FFF0) + 32'd1;
      n_chk++;
      if (sz !== 32'(WIN)) begin
         n_fail++;
         $display("FAIL R2 size actual=%0d expected=%0d", sz, WIN);
      end

      cfg_write(32'h0000_0000, 4'hF);
      expect_now("R3 attributes survive zero write");
      cfg_write(32'h0000_0FF7, 4'hF);
      expect_now("R4 low bits and R3 attributes ignore write");

      cfg_write(32'h8000_0000, 4'hF);
      expect_now("R2 base assigned");
      cfg_write(32'h1234_5678, 4'b0010);
      expect_now("R5 single byte lane");
      cfg_write(32'hFFFF_FFFF, 4'b0000);
      expect_now("R5 no lanes enabled");
      cfg_write(32'hA1FF_FFFF, 4'b1000);
      expect_now("R5 top lane only");

      bus_addr  = 32'hA100_5000;
      decode_en = 1'b0;
      expect_now("R6 in-window address, decode off");
      decode_en = 1'b1;
      expect_now("R7 base address hits");
      bus_addr = 32'hA100_5FFF;
      expect_now("R7 last byte hits");
      bus_addr = 32'hA100_4FFF;
      expect_now("R7 below base misses");
      bus_addr = 32'hA100_6000;
      expect_now("R7 base plus size misses");
      // R8: change inputs between clock edges and sample without an edge
      @(negedge clk);
      bus_addr = 32'hA100_5800;
      #1;
      expect_now("R8 hit follows address combinationally");
      decode_en = 1'b0;
      expect_now("R8 hit drops with decode enable");

      do_reset();
      @(negedge clk);
      expect_now("R9 reset clears base");
      decode_en = 1'b1;
      bus_addr  = 32'h0000_0123;
      expect_now("R9 window back at zero");

      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule